// File: doc/BRIEF.md
# Partitioned Scan Chain with Hold

This block is a scan structure for test mode. Each segment holds a row of scan cells that is cut into equal partitions. A 2:1 multiplexer at the output of each partition picks between that partition's last cell and the serial stream that enters the partition. When a partition's select is high, the partition shifts and sits in the serial path. When the select is low, the multiplexer bypasses the partition, and each of its cells feeds its own stored value back to its input. No clock is gated. Because only one group of cells changes per shift cycle, fewer cell outputs toggle during a shift. A full load or unload still takes one shift cycle per cell of a segment.

Several segments sit side by side. The partitions that share an index across the segments form a cluster, and all partitions in a cluster are driven by one shared select bit. A chain-mode input sets how the segments are fed. In broadcast mode, the primary scan input drives every segment. In serial mode, each segment after the first takes its input from the scan output of the segment before it. When scan enable is low, every cell loads its functional data input in parallel, whatever the select bits are.

The partition count must divide the segment length exactly. If it does not, the block refuses to elaborate.

Top module: `pscan_chain`

## Requirements
- R1: While reset is asserted (active low, asynchronous), every bit of `cell_q` is 0.
- R2: When `scan_en`=1 and `part_sel[j]`=1, on each clock edge the cells of partition j shift by one place. Cell 0 of the partition takes the partition input, and cell i takes the old value of cell i-1. Cell i of partition j in segment k appears on `cell_q[k*CELLS + j*(CELLS/PARTS) + i]`, and cell 0 is nearest the scan input.
- R3: When `scan_en`=1 and `part_sel[j]`=0, every cell of partition j keeps its value across the clock edge.
- R4: The output of partition j is its last cell when `part_sel[j]`=1, and its own input when `part_sel[j]`=0. The input of partition 0 is the segment input, the input of partition j+1 is the output of partition j, and `scan_out[k]` is the output of the last partition of segment k.
- R5: When `scan_en`=0, every cell loads its bit of `func_d` on the clock edge, whatever the value of `part_sel`.
- R6: Select the partitions one at a time, from the last partition to the first, for CELLS/PARTS cycles each. The stream seen on each `scan_out[k]` then equals the stream a flat CELLS-bit shift register would produce, and so do the final cell contents. The whole load and unload takes exactly CELLS cycles.
- R7: `part_sel[j]` controls partition j in every segment at once.
- R8: When `bcast_sel`=1, every segment's input is `scan_in`. When `bcast_sel`=0, segment 0 takes `scan_in` and segment k>0 takes `scan_out[k-1]`.
- R9: In both chain modes, only the partitions whose select bit is 1 change during a shift. All other partitions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1: shift/hold per partition select; 0: functional parallel capture |
| part_sel | input | PARTS | Per-cluster partition select (1 = shift and in path, 0 = bypass and hold) |
| bcast_sel | input | 1 | Chain mode: 1 = broadcast, 0 = serial concatenation |
| scan_in | input | 1 | Primary serial scan input |
| func_d | input | SEGS*CELLS | Functional capture data, one bit per cell |
| cell_q | output | SEGS*CELLS | Cell contents, one bit per cell |
| scan_out | output | SEGS | Serial output of each segment |

## Verification
A table of stimulus steps covers these patterns:
- parallel capture with all selects high and with all selects low;
- a single partition selected;
- several partitions selected at once;
- no partition selected;
- each of the above in both serial and broadcast modes.

After every edge, the cell contents are compared with a model built from the requirements. Each scan output is checked before the edge. These checks separate a partition that leaks shifts from one that holds, and they show which segment input the chain mode picks.

A separate session preloads distinct data into the two segments, then runs the last-to-first activation order in broadcast mode. It compares each output stream and the final contents against a flat shift register. This shows that partitioning changes neither the bit order nor the cycle count.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    // How segments after the first obtain their serial input.
    typedef enum logic {
        CHAIN_SERIAL = 1'b0,
        CHAIN_BCAST  = 1'b1
    } chain_mode_e;

    // Cells held by one partition of a segment.
    function automatic int cells_per_part(input int cells, input int parts);
        return cells / parts;
    endfunction

endpackage

// File: rtl/pscan_part.sv
module pscan_part #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_en,
    input  logic         part_sel,
    input  logic         part_si,
    input  logic [W-1:0] func_d,
    output logic [W-1:0] cells_q,
    output logic         part_so
);

    typedef struct packed {
        logic [W-1:0] cells;
    } part_state_t;

    part_state_t state_d, state_q;
    logic [W:0]  shift_ext;

    always_comb begin
        state_d   = state_q;
        shift_ext = {state_q.cells, part_si};
        if (!scan_en) begin
            state_d.cells = func_d;
        end else if (part_sel) begin
            state_d.cells = shift_ext[W-1:0];
        end
        // part_sel low in scan mode: cells recirculate their own value
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cells_q = state_q.cells;
    assign part_so = part_sel ? state_q.cells[W-1] : part_si;

    // R3: a deselected partition keeps its contents while shifting elsewhere
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !part_sel) |=> $stable(cells_q));

    // R5: functional capture
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (cells_q == $past(func_d)));

    // R2: head cell takes the partition input
    a_r2_shift_head: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && part_sel) |=> (cells_q[0] == $past(part_si)));

    generate
        if (W > 1) begin : g_body_chk
            // R2: remaining cells take their predecessor
            a_r2_shift_body: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && part_sel) |=> (cells_q[W-1:1] == $past(cells_q[W-2:0])));
        end
    endgenerate

endmodule

// File: rtl/pscan_seg.sv
module pscan_seg
    import pscan_pkg::*;
#(
    parameter int CELLS = 8,
    parameter int PARTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic [PARTS-1:0] part_sel,
    input  logic             seg_si,
    input  logic [CELLS-1:0] func_d,
    output logic [CELLS-1:0] cells_q,
    output logic             seg_so
);

    localparam int W = cells_per_part(CELLS, PARTS);

    generate
        if (PARTS < 1 || (CELLS % PARTS) != 0) begin : g_bad_split
            $error("pscan_seg: CELLS must be a non-zero multiple of PARTS");
        end
    endgenerate

    logic [PARTS:0] link;

    assign link[0] = seg_si;

    generate
        for (genvar j = 0; j < PARTS; j++) begin : g_part
            pscan_part #(.W(W)) i_part (
                .clk      (clk),
                .rst_n    (rst_n),
                .scan_en  (scan_en),
                .part_sel (part_sel[j]),
                .part_si  (link[j]),
                .func_d   (func_d[j*W +: W]),
                .cells_q  (cells_q[j*W +: W]),
                .part_so  (link[j+1])
            );
        end
    endgenerate

    assign seg_so = link[PARTS];

    // R4: with every partition bypassed, the segment is a straight wire
    a_r4_bypass_all: assert property (@(posedge clk) disable iff (!rst_n)
        (part_sel == '0) |-> (seg_so == seg_si));

    // R4: with the last partition selected, its tail cell drives the output
    a_r4_last_tail: assert property (@(posedge clk) disable iff (!rst_n)
        part_sel[PARTS-1] |-> (seg_so == cells_q[CELLS-1]));

endmodule

// File: rtl/pscan_chain.sv
module pscan_chain
    import pscan_pkg::*;
#(
    parameter int SEGS  = 2,
    parameter int CELLS = 8,
    parameter int PARTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_en,
    input  logic [PARTS-1:0]      part_sel,
    input  logic                  bcast_sel,
    input  logic                  scan_in,
    input  logic [SEGS*CELLS-1:0] func_d,
    output logic [SEGS*CELLS-1:0] cell_q,
    output logic [SEGS-1:0]       scan_out
);

    chain_mode_e     chain_mode;
    logic [SEGS-1:0] seg_si;

    assign chain_mode = chain_mode_e'(bcast_sel);

    generate
        for (genvar k = 0; k < SEGS; k++) begin : g_seg
            if (k == 0) begin : g_head
                assign seg_si[k] = scan_in;
            end else begin : g_tail
                assign seg_si[k] = (chain_mode == CHAIN_BCAST) ? scan_in : scan_out[k-1];
            end

            pscan_seg #(.CELLS(CELLS), .PARTS(PARTS)) i_seg (
                .clk      (clk),
                .rst_n    (rst_n),
                .scan_en  (scan_en),
                .part_sel (part_sel),
                .seg_si   (seg_si[k]),
                .func_d   (func_d[k*CELLS +: CELLS]),
                .cells_q  (cell_q[k*CELLS +: CELLS]),
                .seg_so   (scan_out[k])
            );

            // R8: in broadcast mode the first partition of every segment sees scan_in
            a_r8_bcast_feed: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && bcast_sel && part_sel[0]) |=> (cell_q[k*CELLS] == $past(scan_in)));
        end
    endgenerate

    // R1: reset clears every cell
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (cell_q == '0));

endmodule

// File: tb/test_pscan_chain.sv
module test_pscan_chain;

    localparam int SEGS       = 2;
    localparam int CELLS      = 8;
    localparam int PARTS      = 4;
    localparam int W          = CELLS / PARTS;
    localparam int TOT        = SEGS * CELLS;
    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 16;

    // step word: [22]=scan_en [21:18]=part_sel [17]=bcast [16]=scan_in [15:0]=func_d
    localparam logic [22:0] STEPS [NSTEP] = '{
        {1'b0, 4'b1111, 1'b0, 1'b0, 16'hA5C3},
        {1'b1, 4'b1000, 1'b0, 1'b1, 16'h0000},
        {1'b1, 4'b1000, 1'b0, 1'b0, 16'h0000},
        {1'b1, 4'b0100, 1'b0, 1'b1, 16'h0000},
        {1'b1, 4'b0010, 1'b1, 1'b1, 16'h0000},
        {1'b1, 4'b0000, 1'b0, 1'b1, 16'hFFFF},
        {1'b1, 4'b0001, 1'b1, 1'b0, 16'h0000},
        {1'b1, 4'b1111, 1'b0, 1'b1, 16'h0000},
        {1'b1, 4'b1111, 1'b0, 1'b0, 16'h0000},
        {1'b1, 4'b0101, 1'b1, 1'b1, 16'h0000},
        {1'b1, 4'b1010, 1'b0, 1'b0, 16'h0000},
        {1'b0, 4'b0000, 1'b0, 1'b0, 16'h3C96},
        {1'b1, 4'b0000, 1'b1, 1'b1, 16'h0000},
        {1'b1, 4'b1001, 1'b0, 1'b1, 16'h0000},
        {1'b1, 4'b0110, 1'b1, 1'b0, 16'h0000},
        {1'b1, 4'b1111, 1'b1, 1'b1, 16'h0000}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             scan_en;
    logic [PARTS-1:0] part_sel;
    logic             bcast_sel;
    logic             scan_in;
    logic [TOT-1:0]   func_d;
    logic [TOT-1:0]   cell_q;
    logic [SEGS-1:0]  scan_out;

    logic [TOT-1:0]   mdl;
    int               n_checks = 0;
    int               n_errors = 0;
    bit               done     = 1'b0;

    pscan_chain #(.SEGS(SEGS), .CELLS(CELLS), .PARTS(PARTS)) i_pscan_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .part_sel  (part_sel),
        .bcast_sel (bcast_sel),
        .scan_in   (scan_in),
        .func_d    (func_d),
        .cell_q    (cell_q),
        .scan_out  (scan_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Scan outputs predicted from the requirements (R4, R8)
    function automatic logic [SEGS-1:0] calc_so();
        logic [SEGS-1:0] r;
        logic x;
        r = '0;
        for (int k = 0; k < SEGS; k++) begin
            if (k == 0 || bcast_sel) x = scan_in;
            else                     x = r[k-1];
            for (int j = 0; j < PARTS; j++)
                if (part_sel[j]) x = mdl[k*CELLS + j*W + W-1];
            r[k] = x;
        end
        return r;
    endfunction

    // Cell contents after one edge (R2, R3, R5, R7, R8, R9)
    function automatic logic [TOT-1:0] calc_next();
        logic [TOT-1:0]  n;
        logic [SEGS-1:0] so;
        logic x;
        int   b;
        if (!scan_en) return func_d;
        n  = mdl;
        so = calc_so();
        for (int k = 0; k < SEGS; k++) begin
            if (k == 0 || bcast_sel) x = scan_in;
            else                     x = so[k-1];
            for (int j = 0; j < PARTS; j++) begin
                if (part_sel[j]) begin
                    b = k*CELLS + j*W;
                    for (int i = W-1; i > 0; i--) n[b+i] = mdl[b+i-1];
                    n[b] = x;
                    x = mdl[b+W-1];
                end
            end
        end
        return n;
    endfunction

    function automatic string step_tag(input logic [22:0] s);
        if (!s[22])                 return "R5";
        if (s[21:18] == '0)         return "R3";
        if (s[17] && $onehot(s[21:18])) return "R8";
        if (s[17])                  return "R9";
        if ($onehot(s[21:18]))      return "R7";
        return "R2";
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [TOT-1:0]   nxt;
        logic [CELLS-1:0] flat [SEGS];
        logic [CELLS-1:0] vec;
        int               cycles;

        rst_n     = 1'b0;
        scan_en   = 1'b0;
        part_sel  = '1;
        bcast_sel = 1'b0;
        scan_in   = 1'b0;
        func_d    = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state even with capture data present
        chk(cell_q == '0, "R1", 64'(cell_q), 64'(0));
        rst_n = 1'b1;
        mdl   = '0;

        // Table walk
        for (int s = 0; s < NSTEP; s++) begin
            scan_en   = STEPS[s][22];
            part_sel  = STEPS[s][21:18];
            bcast_sel = STEPS[s][17];
            scan_in   = STEPS[s][16];
            func_d    = STEPS[s][15:0];
            #1;
            chk(scan_out == calc_so(), "R4", 64'(scan_out), 64'(calc_so()));
            nxt = calc_next();
            @(posedge clk);
            @(negedge clk);
            chk(cell_q == nxt, step_tag(STEPS[s]), 64'(cell_q), 64'(nxt));
            mdl = nxt;
        end

        // R6: partitioned session versus flat shift register, broadcast mode
        scan_en  = 1'b0;
        func_d   = 16'h6D2B;
        @(posedge clk);
        @(negedge clk);
        chk(cell_q == 16'h6D2B, "R5", 64'(cell_q), 64'h6D2B);
        for (int k = 0; k < SEGS; k++) flat[k] = func_d[k*CELLS +: CELLS];
        vec       = 8'b1011_0010;
        scan_en   = 1'b1;
        bcast_sel = 1'b1;
        cycles    = 0;
        for (int j = PARTS-1; j >= 0; j--) begin
            part_sel = PARTS'(1) << j;
            for (int c = 0; c < W; c++) begin
                scan_in = vec[cycles];
                #1;
                for (int k = 0; k < SEGS; k++)
                    chk(scan_out[k] == flat[k][CELLS-1], "R6", 64'(scan_out[k]), 64'(flat[k][CELLS-1]));
                for (int k = 0; k < SEGS; k++) flat[k] = {flat[k][CELLS-2:0], scan_in};
                @(posedge clk);
                @(negedge clk);
                cycles++;
            end
        end
        chk(cycles == CELLS, "R6", 64'(cycles), 64'(CELLS));
        for (int k = 0; k < SEGS; k++)
            chk(cell_q[k*CELLS +: CELLS] == flat[k], "R6", 64'(cell_q[k*CELLS +: CELLS]), 64'(flat[k]));

        // R5: capture ignores a cleared select vector
        scan_en  = 1'b0;
        part_sel = '0;
        func_d   = 16'h0F1E;
        @(posedge clk);
        @(negedge clk);
        chk(cell_q == 16'h0F1E, "R5", 64'(cell_q), 64'h0F1E);

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        chk(cell_q == '0, "R1", 64'(cell_q), 64'(0));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule